// File: doc/BRIEF.md
# Status Register Masked Write Unit

This block holds two 32-bit status words: the live processor status word and a saved copy of it. A move-to-status-register operation updates one of them. It supplies a write value, a 4-bit field mask, a target select and a flag that says whether execution-state bits may be touched. The unit turns these inputs into a per-bit write mask. Only the bits set in that mask take the new value, and every other bit keeps its old contents.

For the live word, the mask depends on the flag and on the privilege level. The privilege level is read from the live word's own mode field. Some field groups therefore open only partly: an unprivileged writer can never alter the mode bits or the interrupt-disable bits. The saved word uses a plain per-byte mask, and privilege has no effect on it. Both words are visible on the outputs at all times.

Top module: `psr_field_writer`

## Requirements
- R1: After reset, `cur_psr` is 32'h0000_0013 (mode field bits 4..0 = 5'b10011, privileged) and `saved_psr` is 32'h0000_0000.
- R2: While `wr_en` is low, neither output changes, whatever the other inputs carry.
- R3: A write with `wr_en` high updates the selected word on the next rising clock edge to (old AND NOT mask) OR (`wr_data` AND mask). `wr_sel` = 0 selects `cur_psr` and 1 selects `saved_psr`. The word that is not selected is unchanged.
- R4: For `cur_psr`, `field_mask[3]` opens bits 31..24 when `state_wr` is 1 and only bits 31..27 when it is 0.
- R5: For `cur_psr`, `field_mask[2]` opens bits 19..16. Bits 23..20 are never written.
- R6: For `cur_psr`, `field_mask[1]` opens bits from a low bit up to a high bit. The high bit is 15 with `state_wr` = 1 and 9 with `state_wr` = 0. The low bit is 8 when privileged and 9 when unprivileged.
- R7: For `cur_psr`, `field_mask[0]` opens bits 7..6 and 4..0 only when privileged.
- R8: For `cur_psr`, `field_mask[0]` opens bit 5 exactly when `state_wr` is 1, independent of privilege.
- R9: The unit is privileged whenever `cur_psr[4:0]` differs from the user encoding 5'b10000. Once in user mode, no write can change the mode field.
- R10: For `saved_psr`, `field_mask[k]` opens byte lane k (bits 8k+7..8k) in full. Neither privilege nor `state_wr` has any effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released internally in step with the clock |
| wr_en | input | 1 | Write strobe, sampled on the rising edge |
| wr_sel | input | 1 | Target: 0 live word, 1 saved word |
| wr_data | input | 32 | Value to be written |
| field_mask | input | 4 | Field mask, one bit per field group |
| state_wr | input | 1 | Allows execution-state bits to be written |
| cur_psr | output | 32 | Live status word |
| saved_psr | output | 32 | Saved status word |

## Verification
Each write produces its result exactly one rising edge after the strobe is sampled. The bench drives inputs on the falling edge, drops the strobe on the next falling edge, and compares both outputs right then, after the single register stage has updated. The hold checks drive a fully populated write with the strobe low and compare on the following falling edge, one full cycle later. Reset values are compared only after the two-stage reset release has completed, and a few more idle cycles are allowed before that comparison.

// File: rtl/psr_pkg.sv
package psr_pkg;

  localparam int PSR_W   = 32;
  localparam int LANE_W  = 8;
  localparam int LANES   = PSR_W / LANE_W;
  localparam int MODE_W  = 5;
  localparam int FIELD_W = LANES;

  localparam logic [MODE_W-1:0] MODE_USER = 5'b10000;
  localparam logic [MODE_W-1:0] MODE_SVC  = 5'b10011;

  // bit positions that fix which bits each field group may touch
  localparam int TOP_HI       = 31;
  localparam int TOP_LO_STATE = 24;
  localparam int TOP_LO_PLAIN = 27;
  localparam int EXT_HI       = 19;
  localparam int EXT_LO       = 16;
  localparam int CTL_HI_STATE = 15;
  localparam int CTL_HI_PLAIN = 9;
  localparam int CTL_LO_PRIV  = 8;
  localparam int CTL_LO_USER  = 9;
  localparam int IRQ_HI       = 7;
  localparam int IRQ_LO       = 6;
  localparam int STATE_BIT    = 5;

  typedef logic [PSR_W-1:0] psr_word_t;

  typedef enum logic {
    TGT_CUR   = 1'b0,
    TGT_SAVED = 1'b1
  } psr_tgt_e;

  localparam psr_word_t CUR_RESET   = psr_word_t'(MODE_SVC);
  localparam psr_word_t SAVED_RESET = '0;

  function automatic psr_word_t bit_span(input int hi, input int lo);
    psr_word_t r;
    r = '0;
    for (int i = 0; i < PSR_W; i++) begin
      if ((i <= hi) && (i >= lo)) r[i] = 1'b1;
    end
    return r;
  endfunction

endpackage

// File: rtl/psr_rst_sync.sv
module psr_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = chain_q[STAGES-1];

endmodule

// File: rtl/psr_cur_mask.sv
module psr_cur_mask
  import psr_pkg::*;
(
  input  logic [FIELD_W-1:0] field_mask,
  input  logic               state_wr,
  input  logic               priv,
  output psr_word_t          mask
);

  always_comb begin
    int top_lo;
    int ctl_hi;
    int ctl_lo;
    top_lo = state_wr ? TOP_LO_STATE : TOP_LO_PLAIN;
    ctl_hi = state_wr ? CTL_HI_STATE : CTL_HI_PLAIN;
    ctl_lo = priv ? CTL_LO_PRIV : CTL_LO_USER;
    mask   = '0;
    if (field_mask[3]) mask |= bit_span(TOP_HI, top_lo);
    if (field_mask[2]) mask |= bit_span(EXT_HI, EXT_LO);
    if (field_mask[1]) mask |= bit_span(ctl_hi, ctl_lo);
    if (field_mask[0]) begin
      if (priv) begin
        mask |= bit_span(IRQ_HI, IRQ_LO);
        mask |= bit_span(MODE_W-1, 0);
      end
      if (state_wr) mask[STATE_BIT] = 1'b1;
    end
  end

endmodule

// File: rtl/psr_saved_mask.sv
module psr_saved_mask
  import psr_pkg::*;
(
  input  logic [FIELD_W-1:0] field_mask,
  output psr_word_t          mask
);

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign mask[g*LANE_W +: LANE_W] = {LANE_W{field_mask[g]}};
  end

endmodule

// File: rtl/psr_merge.sv
module psr_merge #(
  parameter int W = 32
) (
  input  logic [W-1:0] old_val,
  input  logic [W-1:0] new_val,
  input  logic [W-1:0] mask,
  output logic [W-1:0] merged
);

  assign merged = (old_val & ~mask) | (new_val & mask);

endmodule

// File: rtl/psr_field_writer.sv
module psr_field_writer
  import psr_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              wr_sel,
  input  logic [PSR_W-1:0]  wr_data,
  input  logic [FIELD_W-1:0] field_mask,
  input  logic              state_wr,
  output logic [PSR_W-1:0]  cur_psr,
  output logic [PSR_W-1:0]  saved_psr
);

  logic      rst_core_n;
  psr_tgt_e  tgt;
  logic      priv;
  logic      cur_en, saved_en;
  psr_word_t cur_q, cur_d, saved_q, saved_d;
  psr_word_t cur_mask, saved_mask;
  psr_word_t cur_merged, saved_merged;

  psr_rst_sync #(.STAGES(2)) u_rst (
    .clk       (clk),
    .rst_n     (rst_n),
    .rst_sync_n(rst_core_n)
  );

  assign tgt  = psr_tgt_e'(wr_sel);
  assign priv = (cur_q[MODE_W-1:0] != MODE_USER);

  psr_cur_mask u_cur_mask (
    .field_mask(field_mask),
    .state_wr  (state_wr),
    .priv      (priv),
    .mask      (cur_mask)
  );

  psr_saved_mask u_saved_mask (
    .field_mask(field_mask),
    .mask      (saved_mask)
  );

  psr_merge #(.W(PSR_W)) u_cur_merge (
    .old_val(cur_q),
    .new_val(wr_data),
    .mask   (cur_mask),
    .merged (cur_merged)
  );

  psr_merge #(.W(PSR_W)) u_saved_merge (
    .old_val(saved_q),
    .new_val(wr_data),
    .mask   (saved_mask),
    .merged (saved_merged)
  );

  // next-state
  always_comb begin
    cur_en   = wr_en && (tgt == TGT_CUR);
    saved_en = wr_en && (tgt == TGT_SAVED);
    cur_d    = cur_en   ? cur_merged   : cur_q;
    saved_d  = saved_en ? saved_merged : saved_q;
  end

  // registers
  always_ff @(posedge clk or negedge rst_core_n) begin
    if (!rst_core_n) begin
      cur_q   <= CUR_RESET;
      saved_q <= SAVED_RESET;
    end else begin
      if (cur_en)   cur_q   <= cur_d;
      if (saved_en) saved_q <= saved_d;
    end
  end

  assign cur_psr   = cur_q;
  assign saved_psr = saved_q;

endmodule

// File: rtl/psr_field_writer_chk.sv
module psr_field_writer_chk
  import psr_pkg::*;
(
  input logic               clk,
  input logic               rst_n,
  input logic               core_rst_n,
  input logic               wr_en,
  input logic               wr_sel,
  input logic [FIELD_W-1:0] field_mask,
  input logic               state_wr,
  input logic [PSR_W-1:0]   cur_psr,
  input logic [PSR_W-1:0]   saved_psr
);

  // R1
  reset_value_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(core_rst_n) |-> (cur_psr == CUR_RESET) && (saved_psr == SAVED_RESET));

  // R2
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n || !core_rst_n)
    !wr_en |=> $stable(cur_psr) && $stable(saved_psr));

  // R3
  other_word_hold_chk: assert property (@(posedge clk) disable iff (!rst_n || !core_rst_n)
    (wr_en && wr_sel) |=> $stable(cur_psr));

  // R5
  cur_gap_hold_chk: assert property (@(posedge clk) disable iff (!rst_n || !core_rst_n)
    1'b1 |=> $stable(cur_psr[23:20]));

  // R9
  user_mode_lock_chk: assert property (@(posedge clk) disable iff (!rst_n || !core_rst_n)
    (wr_en && !wr_sel && cur_psr[MODE_W-1:0] == MODE_USER)
      |=> $stable(cur_psr[4:0]) && $stable(cur_psr[8:6]));

  // R8
  state_bits_lock_chk: assert property (@(posedge clk) disable iff (!rst_n || !core_rst_n)
    (wr_en && !wr_sel && !state_wr)
      |=> $stable(cur_psr[5]) && $stable(cur_psr[26:24]) && $stable(cur_psr[15:10]));

  // R10
  saved_empty_mask_chk: assert property (@(posedge clk) disable iff (!rst_n || !core_rst_n)
    (wr_en && wr_sel && field_mask == '0) |=> $stable(saved_psr));

endmodule

bind psr_field_writer psr_field_writer_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .core_rst_n(rst_core_n),
  .wr_en     (wr_en),
  .wr_sel    (wr_sel),
  .field_mask(field_mask),
  .state_wr  (state_wr),
  .cur_psr   (cur_psr),
  .saved_psr (saved_psr)
);

// File: tb/psr_field_writer_tb.sv
`timescale 1ns/1ps
module psr_field_writer_tb_top;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        wr_en;
  logic        wr_sel;
  logic [31:0] wr_data;
  logic [3:0]  field_mask;
  logic        state_wr;
  logic [31:0] cur_psr;
  logic [31:0] saved_psr;

  int checks = 0;
  int errors = 0;

  logic [31:0] m_cur, m_sav;

  always #10 clk = ~clk;

  psr_field_writer dut_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel),
    .wr_data(wr_data), .field_mask(field_mask), .state_wr(state_wr),
    .cur_psr(cur_psr), .saved_psr(saved_psr)
  );

  function automatic logic [31:0] exp_mask(input logic sel, input logic [3:0] fm,
                                           input logic st, input logic pv);
    logic [31:0] r;
    r = '0;
    for (int b = 0; b < 32; b++) begin
      if (sel) r[b] = fm[b/8];
      else if (b >= 24) r[b] = fm[3] && (st || b >= 27);
      else if (b >= 16) r[b] = fm[2] && (b <= 19);
      else if (b >= 8)  r[b] = fm[1] && (b <= 9 || st) && (b >= 9 || pv);
      else if (b == 5)  r[b] = fm[0] && st;
      else              r[b] = fm[0] && pv;
    end
    return r;
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; wr_en = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    m_cur = 32'h0000_0013;
    m_sav = 32'h0;
    check("R1 cur", cur_psr, m_cur);
    check("R1 saved", saved_psr, m_sav);
  endtask

  task automatic do_write(input logic sel, input logic [31:0] d,
                          input logic [3:0] fm, input logic st);
    logic [31:0] mk;
    @(negedge clk);
    wr_en = 1'b1; wr_sel = sel; wr_data = d; field_mask = fm; state_wr = st;
    mk = exp_mask(sel, fm, st, m_cur[4:0] != 5'b10000);
    if (sel) m_sav = (m_sav & ~mk) | (d & mk);
    else     m_cur = (m_cur & ~mk) | (d & mk);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0; wr_en = 1'b0; wr_sel = 1'b0; wr_data = '0;
    field_mask = '0; state_wr = 1'b0;
    for (int tg = 0; tg < 2; tg++)
      for (int pv = 0; pv < 2; pv++)
        for (int st = 0; st < 2; st++)
          for (int fm = 0; fm < 16; fm++)
            for (int pat = 0; pat < 2; pat++) begin
              logic [31:0] pre_c, pre_s, d;
              do_reset();
              if (pv == 0) begin
                do_write(1'b0, 32'h0000_0010, 4'b0001, 1'b0);
                check("R9 enter user", cur_psr, m_cur);
              end
              pre_c = pat ? 32'hA5C3_5A3C : 32'h0F0F_F0F0;
              pre_c[4:0] = pv ? 5'b10011 : 5'b10000;
              pre_s = pat ? 32'h3C5A_C3A5 : 32'hF0F0_0F0F;
              do_write(1'b0, pre_c, 4'hF, 1'b1);
              do_write(1'b1, pre_s, 4'hF, 1'b0);
              d = ~(pat ? 32'hA5C3_5A3C : 32'h0F0F_F0F0) ^ 32'h0000_000C;
              if (pv == 1) d[4:0] = pat ? 5'b11111 : 5'b10111;
              do_write(tg[0], d, fm[3:0], st[0]);
              if (tg == 1) begin
                check("R10 saved", saved_psr, m_sav);
                check("R3 cur untouched", cur_psr, m_cur);
              end else begin
                check("R4 cur[31:24]", {24'h0, cur_psr[31:24]}, {24'h0, m_cur[31:24]});
                check("R5 cur[23:16]", {24'h0, cur_psr[23:16]}, {24'h0, m_cur[23:16]});
                check("R6 cur[15:8]",  {24'h0, cur_psr[15:8]},  {24'h0, m_cur[15:8]});
                check("R7 cur[7:6,4:0]", {24'h0, cur_psr[7:6], 1'b0, cur_psr[4:0]},
                                         {24'h0, m_cur[7:6], 1'b0, m_cur[4:0]});
                check("R8 cur[5]", {31'h0, cur_psr[5]}, {31'h0, m_cur[5]});
                check("R3 saved untouched", saved_psr, m_sav);
                if (pv == 0)
                  check("R9 mode locked", {27'h0, cur_psr[4:0]}, 32'h10);
              end
              @(negedge clk);
              wr_en = 1'b0; wr_sel = tg[0]; wr_data = ~d;
              field_mask = 4'hF; state_wr = 1'b1;
              @(negedge clk);
              check("R2 cur hold", cur_psr, m_cur);
              check("R2 saved hold", saved_psr, m_sav);
            end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule